// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Bypass

This block is a small in-order queue that sits between a write-through cache and main memory. Every store the processor commits is written to the cache and, at the same time, handed to this queue with its address and data. The queue sends the stores to memory one at a time, oldest first.

A read miss from the cache also needs main memory. The block compares the miss address with the address of every store still held in the queue. If none of them match, the read goes to memory ahead of the queued stores, so the processor is not delayed by stores it does not depend on. If one of them matches, the read is held back and `rd_blocked` is raised. The read is released once every matching store has been written, and so every store older than it has been written too.

Main memory is reached through a single request port that carries either a read or a write. Both the store input and the memory port use valid/ready handshakes. A transaction moves when valid and ready are both high at a clock edge. A sender that has raised valid keeps valid and its payload steady until that happens. The read requester follows the same rule for `rd_valid` and `rd_addr`, and `rd_ready` tells it that its read was accepted.

Top module: `wt_store_buffer`

## Requirements
- R1: Reset (active-low, asynchronous) empties the queue. While reset is asserted and after it is released, `st_ready` is 1 and `mem_valid` is 0 until a store or a read arrives.
- R2: A store is taken when `st_valid` and `st_ready` are both 1. Stores appear on the memory port as writes (`mem_we` = 1) in the order they were taken, with their address and data unchanged. Each leaves the queue when `mem_valid` and `mem_ready` are both 1. With nothing queued and no read pending, `mem_valid` is 0.
- R3: `st_ready` is 0 exactly when all DEPTH (default 4) entries are occupied.
- R4: A read whose address matches no queued store, arriving while no transaction is held on the memory port, is presented on the memory port in the same cycle (`mem_we` = 0, `mem_addr` = `rd_addr`), ahead of any older queued stores.
- R5: A read matches a queued store when the full addresses are equal. While any matching store is queued, `rd_blocked` is 1 and the read is not presented. Stores keep draining during this time.
- R6: A transaction presented on the memory port and not accepted stays the same in the next cycle. A write that has started completes before any read is granted. A presented read is not replaced by a write.
- R7: A store taken in the same cycle as a write drains leaves the occupancy unchanged.
- R8: `rd_ready` is 1 only in a cycle in which the memory accepts the read (`mem_valid` = 1, `mem_we` = 0, `mem_ready` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store offered |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss waiting for memory |
| rd_ready | output | 1 | Read accepted by memory this cycle |
| rd_addr | input | AW | Read miss address |
| rd_blocked | output | 1 | Read held back by a matching queued store |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 = write (drained store), 0 = read |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |

## Verification
Directed sequences fill the queue while memory stalls. They then issue a read that hits the second queued store and let writes drain one at a time. This shows that the read stays blocked until the matching store is gone, and that it then overtakes the stores still queued. A full queue with a store and a drain in the same cycle tells a correct occupancy update apart from an off-by-one that ends the stall late or early. Random traffic mixes bursty memory back-pressure with reads that are either drawn from queued addresses or fresh. This separates correct priority and hold behaviour from designs that lose ordering, let a read past a started write, or miss a conflict. A reset while the queue holds entries shows that the queued stores are dropped.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Which requester currently holds the memory port.
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_WR   = 2'd1,
    OWN_RD   = 2'd2
  } own_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic                      empty,
  output logic                      full,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0]          ent_vld
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DEPTH-1:0][AW-1:0] slot_a;
  logic [DEPTH-1:0][DW-1:0] slot_d;
  logic [DEPTH-1:0]         slot_v;
  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [CW-1:0]            cnt;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // Pointers, occupancy and per-slot valid flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      slot_v <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wr_ptr == PW'(i))     slot_v[i] <= 1'b1;
        else if (pop && rd_ptr == PW'(i)) slot_v[i] <= 1'b0;
      end
    end
  end

  // Payload storage, no reset needed.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && wr_ptr == PW'(i)) begin
        slot_a[i] <= push_addr;
        slot_d[i] <= push_data;
      end
    end
  end

  assign head_addr = slot_a[rd_ptr];
  assign head_data = slot_d[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign occ       = cnt;
  assign ent_addr  = slot_a;
  assign ent_vld   = slot_v;
endmodule

// File: rtl/sb_addr_match.sv
module sb_addr_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic [AW-1:0]            probe_addr,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0]         ent_vld,
  output logic                     any_hit
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_addr[g] == probe_addr);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/sb_port_arb.sv
module sb_port_arb #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_conflict,
  input  logic          wr_pending,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wr_take,
  output logic          rd_ready,
  output logic          rd_blocked
);
  import sb_pkg::*;

  own_e own_q, gnt;

  // A held transaction keeps the port; otherwise a clean read wins.
  always_comb begin
    gnt = OWN_NONE;
    if (own_q == OWN_WR)                gnt = OWN_WR;
    else if (own_q == OWN_RD)           gnt = OWN_RD;
    else if (rd_valid && !rd_conflict)  gnt = OWN_RD;
    else if (wr_pending)                gnt = OWN_WR;
  end

  assign mem_valid  = (gnt == OWN_WR) || ((gnt == OWN_RD) && rd_valid);
  assign mem_we     = (gnt == OWN_WR);
  assign mem_addr   = (gnt == OWN_WR) ? head_addr : rd_addr;
  assign mem_wdata  = (gnt == OWN_WR) ? head_data : '0;
  assign wr_take    = (gnt == OWN_WR) && mem_ready;
  assign rd_ready   = (gnt == OWN_RD) && rd_valid && mem_ready;
  assign rd_blocked = rd_valid && rd_conflict && (own_q != OWN_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      own_q <= OWN_NONE;
    else if (mem_valid && !mem_ready) own_q <= gnt;
    else                             own_q <= OWN_NONE;
  end
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_blocked,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int CW = $clog2(DEPTH+1);

  logic                     push, pop, empty, full, conflict;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [CW-1:0]            occ;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0]         ent_vld;

  assign st_ready = !full;
  assign push     = st_valid && st_ready;

  sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop),
    .head_addr(head_addr), .head_data(head_data),
    .empty(empty), .full(full), .occ(occ),
    .ent_addr(ent_addr), .ent_vld(ent_vld)
  );

  sb_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .probe_addr(rd_addr), .ent_addr(ent_addr), .ent_vld(ent_vld),
    .any_hit(conflict)
  );

  sb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_conflict(conflict),
    .wr_pending(!empty), .head_addr(head_addr), .head_data(head_data),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata),
    .wr_take(pop), .rd_ready(rd_ready), .rd_blocked(rd_blocked)
  );
endmodule

// File: rtl/wt_store_buffer_chk.sv
module wt_store_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       st_valid,
  input logic                       st_ready,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic                       rd_blocked,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic                       mem_we,
  input logic [AW-1:0]              mem_addr,
  input logic [DW-1:0]              mem_wdata,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> (occ == 0) && st_ready); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) && !rd_valid |-> !mem_valid); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH) |-> !st_ready); // R3

  AST_BLOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blocked |-> !rd_ready); // R5

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && !mem_ready |=>
      mem_valid && mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R6

  AST_READ_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && !mem_ready |=> !(mem_valid && mem_we)); // R6

  AST_OCC_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && mem_valid && mem_we && mem_ready |=>
      occ == $past(occ)); // R7

  AST_READ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> mem_valid && !mem_we && mem_ready && rd_valid); // R8
endmodule

bind wt_store_buffer wt_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_blocked(rd_blocked),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .occ(occ)
);

// File: tb/wt_store_buffer_test.sv
`timescale 1ns/1ps
module wt_store_buffer_test;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          rd_valid, rd_ready, rd_blocked;
  logic [AW-1:0] rd_addr;
  logic          mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  wt_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_blocked(rd_blocked),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench model: queued stores oldest first, and the held-port state.
  logic [AW-1:0] q_a [DEPTH];
  logic [DW-1:0] q_d [DEPTH];
  int q_n   = 0;
  int lock  = 0;   // 0 none, 1 write held, 2 read held
  bit rd_done = 1'b0;

  function automatic bit q_hit(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (i < q_n && q_a[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit bm, ev, ewe;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    string tg;
    #1;
    bm = rd_valid && q_hit(rd_addr);
    ev = 1'b0; ewe = 1'b0; ed = '0;
    if (lock == 1)                begin ev = 1'b1; ewe = 1'b1; end
    else if (lock == 2)           ev = rd_valid;
    else if (rd_valid && !bm)     ev = 1'b1;
    else if (q_n > 0)             begin ev = 1'b1; ewe = 1'b1; end
    if (ewe) begin ea = q_a[0]; ed = q_d[0]; end else ea = rd_addr;
    if (lock != 0)             tg = "R6";
    else if (ev && !ewe)       tg = "R4";
    else                       tg = "R2";
    check("R3 st_ready", 64'(st_ready), 64'(q_n < DEPTH));
    check("R5 rd_blocked", 64'(rd_blocked), 64'(rd_valid && bm && lock != 2));
    check({tg, " mem_valid"}, 64'(mem_valid), 64'(ev));
    if (ev) begin
      check({tg, " mem_we"}, 64'(mem_we), 64'(ewe));
      check({tg, " mem_addr"}, 64'(mem_addr), 64'(ea));
      if (ewe) check({tg, " mem_wdata"}, 64'(mem_wdata), 64'(ed));
    end
    check("R8 rd_ready", 64'(rd_ready), 64'(ev && !ewe && mem_ready));
    // Advance the model to the coming edge.
    rd_done = ev && !ewe && mem_ready;
    if (st_valid && q_n < DEPTH && ev && ewe && mem_ready) begin
      for (int i = 0; i < DEPTH-1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; end
      q_a[q_n-1] = st_addr; q_d[q_n-1] = st_data;
    end else if (ev && ewe && mem_ready) begin
      for (int i = 0; i < DEPTH-1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; end
      q_n--;
    end else if (st_valid && q_n < DEPTH) begin
      q_a[q_n] = st_addr; q_d[q_n] = st_data; q_n++;
    end
    lock = (ev && !mem_ready) ? (ewe ? 1 : 2) : 0;
  endtask

  task automatic cyc(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                     input bit rv, input logic [AW-1:0] ra, input bit mr);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    rd_valid = rv; rd_addr = ra; mem_ready = mr;
    step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; st_valid = 0; rd_valid = 0; mem_ready = 0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    q_n = 0; lock = 0; rd_done = 0;
    #1;
    check("R1 st_ready in reset", 64'(st_ready), 64'd1);
    check("R1 mem_valid in reset", 64'(mem_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 st_ready after reset", 64'(st_ready), 64'd1);
    check("R1 mem_valid after reset", 64'(mem_valid), 64'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] ra;
    bit rv;
    int seed_val;
    seed_val = $urandom(32'd2024);
    rst_n = 1'b0; st_valid = 0; rd_valid = 0; mem_ready = 0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    do_reset();

    // Three stores while memory stalls; first write becomes held.
    cyc(1, 16'h0100, 32'hA1A1_0001, 0, 16'h0, 0);
    cyc(1, 16'h0104, 32'hA2A2_0002, 0, 16'h0, 0);
    cyc(1, 16'h0108, 32'hA3A3_0003, 0, 16'h0, 0);
    // R5: read hits the second store; R6: held write keeps the port.
    cyc(0, 16'h0, 32'h0, 1, 16'h0104, 0);
    check("R5 directed block", 64'(rd_blocked), 64'd1);
    cyc(0, 16'h0, 32'h0, 1, 16'h0104, 1);
    cyc(0, 16'h0, 32'h0, 1, 16'h0104, 1);
    // R4: matching store gone, read overtakes the store at 0x0108.
    cyc(0, 16'h0, 32'h0, 1, 16'h0104, 1);
    check("R4 directed read first", 64'(mem_we), 64'd0);
    // R3: fill to DEPTH while memory stalls.
    cyc(1, 16'h0200, 32'hB0B0_0000, 0, 16'h0, 0);
    cyc(1, 16'h0204, 32'hB1B1_0001, 0, 16'h0, 0);
    cyc(1, 16'h0208, 32'hB2B2_0002, 0, 16'h0, 0);
    cyc(1, 16'h020C, 32'hB3B3_0003, 0, 16'h0, 0);
    check("R3 directed full", 64'(st_ready), 64'd0);
    // R7: drain one, then push and drain together, occupancy stays at 3.
    cyc(0, 16'h0, 32'h0, 0, 16'h0, 1);
    cyc(1, 16'h0210, 32'hB4B4_0004, 0, 16'h0, 1);
    cyc(0, 16'h0, 32'h0, 0, 16'h0, 0);
    check("R7 count kept by push+drain", 64'(st_ready), 64'd1);
    cyc(1, 16'h0214, 32'hB5B5_0005, 0, 16'h0, 0);
    cyc(0, 16'h0, 32'h0, 0, 16'h0, 0);
    check("R7 full after one more push", 64'(st_ready), 64'd0);
    for (int i = 0; i < 8; i++) cyc(0, 16'h0, 32'h0, 0, 16'h0, 1);

    // Random traffic.
    rv = 0; ra = '0;
    for (int i = 0; i < 3000; i++) begin
      bit mr;
      if (rv && !rd_done) begin
        // hold the pending read
      end else if ($urandom % 4 == 0) begin
        rv = 1;
        if (q_n > 0 && ($urandom % 2 == 0)) ra = q_a[$urandom % q_n];
        else ra = AW'($urandom % 64);
      end else rv = 0;
      mr = ((i / 400) % 2 == 0) ? ($urandom % 4 != 0) : ($urandom % 3 == 0);
      cyc($urandom % 3 != 0, AW'($urandom % 64), $urandom, rv, ra, mr);
    end
    rv = 0;
    for (int i = 0; i < 4; i++) cyc(1, AW'(16'h0300 + i), $urandom, 0, 16'h0, 0);
    // R1: reset while entries are queued drops them.
    do_reset();
    cyc(0, 16'h0, 32'h0, 0, 16'h0, 1);
    check("R1 queue emptied by reset", 64'(mem_valid), 64'd0);
    for (int i = 0; i < 20; i++)
      cyc($urandom % 2 == 0, AW'($urandom % 16), $urandom, 0, 16'h0, $urandom % 2 == 0);

    done = 1'b1;
    finish_run();
  end
endmodule